// File: doc/BRIEF.md
# Random Generator Control and Status Unit

This block is the register front end of a true-random-number peripheral. Software reaches it over a simple 32-bit register bus with five registers: control, status, data, noise-source control and health-test setup. It gates sample generation, sequences a self-clearing conditional reset through which configuration is committed, divides the sampling clock by a power of two, locks the configuration, and reports data-ready along with seed and clock fault flags. An LFSR stands in for the entropy source. Three verification pins inject a recoverable seed fault, a persistent seed fault and a clock fault.

Software turns on the enable bit and polls data-ready. It then reads the data register, and each such read pops one 32-bit word. To change the configuration, software writes the new fields together with the conditional-reset bit, then writes that bit back to 0. After the second write the bit keeps reading 1 for a fixed number of cycles. A persistent seed fault is cleared by that same sequence. A recoverable one clears its current flag by itself and leaves only the sticky interrupt flag for software to clear.

Top module: `trng_ctrl_unit`

## Requirements
- R1: After reset the control, status, data, noise and health registers all read 0.
- R2: With enable (control bit 2) set, the unit produces words in order from a 32-bit Galois LFSR. The LFSR shifts right and XORs in taps 0x80200003 when the bit shifted out is 1, and its seed is 0x00000001. Word n is the LFSR state after 4n steps. A word that is discarded while ready is lost, and the next word comes 4 steps later.
- R3: A read of the data register (0x08) while data-ready (status bit 0) is set returns the word and clears data-ready. A read while data-ready is clear returns 0 and has no effect.
- R4: The LFSR steps once every 2^div clocks, where div is control bits 19:16. Data-ready therefore returns exactly 4·2^div clock edges after the edge that popped the previous word.
- R5: A control write changes the configuration fields (bits 25:8 and bit 5) only if the same write sets bit 30. Otherwise those fields keep their values.
- R6: A control write with bit 30 set holds the unit in conditional reset. After the next control write with bit 30 clear, bit 30 keeps reading 1 for RST_CYCLES (4) cycles and then reads 0. No word becomes ready while bit 30 reads 1.
- R7: A recoverable seed fault sets status bits 6 and 2 and clears data-ready, and the data register then reads 0. Bit 2 clears by itself AUTO_CYCLES (6) cycles later, while bit 6 stays set.
- R8: A persistent seed fault keeps status bit 2 set until a conditional reset completes. That completion clears both bit 2 and bit 6, and generation resumes.
- R9: Writing 0 to status bit 6 or bit 5 clears that flag. Writing 1 to it leaves it unchanged.
- R10: Clock faults are recorded only while control bit 5 is 1. Status bit 1 follows the fault pin one cycle later, status bit 5 is sticky, and generation does not stop.
- R11: The noise register (0x0C) keeps only its low 18 bits. The health register (0x10) keeps all 32.
- R12: Writing control bit 31 as 1 sets a lock that only reset clears. While locked, the configuration fields and the noise and health registers ignore writes, but generation still works.
- R13: Clearing enable drops data-ready within one cycle and stops generation. The configuration is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address (0x00 control, 0x04 status, 0x08 data, 0x0C noise, 0x10 health) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| inj_seed_soft | input | 1 | Inject a self-recovering seed fault |
| inj_seed_fatal | input | 1 | Inject a seed fault that needs a conditional reset |
| clk_fault | input | 1 | Clock fault indication |

## Verification
The bench injects faults only while a word is ready. A unit that kept the faulted word, or that stepped the LFSR while halted, would then deliver a word off the predicted sequence. It measures the exact number of edges from a pop to the next data-ready at two divider settings, so an off-by-one prescaler shows up. It also checks that configuration written without the reset bit, and noise and health writes made under lock, leave the readback unchanged. For the two seed-fault kinds it checks that the current flag clears by itself only for the recoverable fault, and that a write of 1 cannot clear an interrupt flag.

// File: rtl/trng_pkg.sv
// Shared definitions for the random generator control unit:
// register offsets, bit positions, the flag bundle and the LFSR step.
// Assumes a byte-addressed bus with word-aligned registers.
package trng_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] REG_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] REG_STAT   = 5'h04;
    localparam logic [ADDR_W-1:0] REG_DATA   = 5'h08;
    localparam logic [ADDR_W-1:0] REG_NOISE  = 5'h0C;
    localparam logic [ADDR_W-1:0] REG_HEALTH = 5'h10;

    // Control bit positions
    localparam int C_EN     = 2;
    localparam int C_CLKCHK = 5;
    localparam int C_DIV_LO = 16;
    localparam int C_RECOND = 30;
    localparam int C_LOCK   = 31;

    // Configuration bits that are committed only through conditional reset
    localparam logic [31:0] CFG_MASK = 32'h03FF_FF20;

    // Status bit positions
    localparam int S_READY    = 0;
    localparam int S_CLK_CUR  = 1;
    localparam int S_SEED_CUR = 2;
    localparam int S_CLK_INT  = 5;
    localparam int S_SEED_INT = 6;

    typedef struct packed {
        logic seed_int;
        logic clk_int;
        logic seed_cur;
        logic clk_cur;
    } trng_flags_t;

    // One right-shifting Galois LFSR step
    function automatic logic [31:0] lfsr_step(input logic [31:0] s, input logic [31:0] taps);
        return {1'b0, s[31:1]} ^ (s[0] ? taps : 32'h0);
    endfunction
endpackage

// File: rtl/trng_prescaler.sv
// Power-of-two sample clock divider.
// Emits one tick every 2^div cycles while gen is high; the phase restarts
// whenever gen drops. Assumes div never exceeds 2^DIV_W - 1.
module trng_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected exponent
    assign limit = ~({CNT_W{1'b1}} << div);
    assign tick  = gen && (cnt == limit);

    // Phase counter, cleared when idle or on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!gen || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/trng_word_source.sv
// LFSR stand-in for the entropy source plus word assembly.
// Steps the LFSR on each prescaler tick while running and not holding a
// word; after WORD_TICKS ticks the state becomes the ready word. Dropping
// run discards any held word and restarts assembly.
module trng_word_source #(
    parameter int          DIV_W      = 4,
    parameter int          WORD_TICKS = 4,
    parameter logic [31:0] TAPS       = 32'h8020_0003,
    parameter logic [31:0] SEED       = 32'h0000_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pop,
    input  logic [DIV_W-1:0] div,
    output logic [31:0]      word,
    output logic             ready
);
    import trng_pkg::*;

    localparam int TCNT_W = (WORD_TICKS > 1) ? $clog2(WORD_TICKS) : 1;
    localparam logic [TCNT_W-1:0] LAST = TCNT_W'(WORD_TICKS - 1);

    logic [31:0]       lfsr_q;
    logic [31:0]       lfsr_nxt;
    logic [TCNT_W-1:0] tcnt;
    logic              gen;
    logic              tick;

    assign gen      = run && !ready;
    assign lfsr_nxt = lfsr_step(lfsr_q, TAPS);

    trng_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .gen  (gen),
        .div  (div),
        .tick (tick)
    );

    // LFSR advances only on ticks
    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr_q <= SEED;
        else if (tick)
            lfsr_q <= lfsr_nxt;
    end

    // Word assembly, ready flag and discard
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
            tcnt  <= '0;
            word  <= '0;
        end else if (!run) begin
            ready <= 1'b0;
            tcnt  <= '0;
        end else if (pop) begin
            ready <= 1'b0;
        end else if (tick) begin
            if (tcnt == LAST) begin
                ready <= 1'b1;
                word  <= lfsr_nxt;
                tcnt  <= '0;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/trng_status.sv
// Seed and clock fault flags.
// A recoverable seed fault clears its current flag after AUTO_CYCLES; a
// persistent one waits for a completed conditional reset. Interrupt flags
// are sticky and clear on a written 0. Assumes AUTO_CYCLES >= 1.
module trng_status #(
    parameter int AUTO_CYCLES = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inj_soft,
    input  logic                  inj_fatal,
    input  logic                  clk_fault,
    input  logic                  clk_chk_en,
    input  logic                  recond_done,
    input  logic                  clr_seed_int,
    input  logic                  clr_clk_int,
    output trng_pkg::trng_flags_t flags
);
    localparam int AUTO_W = $clog2(AUTO_CYCLES + 1);
    localparam logic [AUTO_W-1:0] AUTO_LOAD = AUTO_W'(AUTO_CYCLES);

    logic [AUTO_W-1:0] auto_cnt;

    // Seed fault flags and auto-recovery countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags.seed_cur <= 1'b0;
            flags.seed_int <= 1'b0;
            auto_cnt       <= '0;
        end else if (inj_soft || inj_fatal) begin
            flags.seed_cur <= 1'b1;
            flags.seed_int <= 1'b1;
            auto_cnt       <= inj_fatal ? '0 : AUTO_LOAD;
        end else if (recond_done) begin
            flags.seed_cur <= 1'b0;
            flags.seed_int <= 1'b0;
            auto_cnt       <= '0;
        end else begin
            if (auto_cnt == AUTO_W'(1))
                flags.seed_cur <= 1'b0;
            if (auto_cnt != '0)
                auto_cnt <= auto_cnt - 1'b1;
            if (clr_seed_int)
                flags.seed_int <= 1'b0;
        end
    end

    // Clock fault flags, gated by the detection enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags.clk_cur <= 1'b0;
            flags.clk_int <= 1'b0;
        end else begin
            flags.clk_cur <= clk_chk_en && clk_fault;
            if (clk_chk_en && clk_fault)
                flags.clk_int <= 1'b1;
            else if (clr_clk_int)
                flags.clk_int <= 1'b0;
        end
    end
endmodule

// File: rtl/trng_ctrl_unit.sv
// Register front end of the random generator.
// Decodes the five registers, commits configuration only through the
// conditional-reset bit, sequences the reset countdown, applies the lock,
// and routes pops and fault flags. Reads are combinational; a data read
// pops on the clock edge of the access.
module trng_ctrl_unit #(
    parameter int          DIV_W       = 4,
    parameter int          NOISE_W     = 18,
    parameter int          RST_CYCLES  = 4,
    parameter int          AUTO_CYCLES = 6,
    parameter int          WORD_TICKS  = 4,
    parameter logic [31:0] LFSR_TAPS   = 32'h8020_0003,
    parameter logic [31:0] LFSR_SEED   = 32'h0000_0001
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [trng_pkg::ADDR_W-1:0] bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic                       inj_seed_soft,
    input  logic                       inj_seed_fatal,
    input  logic                       clk_fault
);
    import trng_pkg::*;

    localparam int CR_W = $clog2(RST_CYCLES + 1);
    localparam logic [CR_W-1:0] CR_LOAD = CR_W'(RST_CYCLES);

    logic               en_q;
    logic               lock_q;
    logic [31:0]        cfg_q;
    logic               cr_hold_q;
    logic [CR_W-1:0]    cr_cnt_q;
    logic [NOISE_W-1:0] noise_q;
    logic [31:0]        health_q;

    logic               wr_ctrl, wr_stat, wr_noise, wr_health, rd_data;
    logic               busy, recond_done, run, pop;
    logic               ready, seed_cur;
    logic [31:0]        word;
    trng_flags_t        flags;

    assign wr_ctrl   = bus_sel && bus_wr && (bus_addr == REG_CTRL);
    assign wr_stat   = bus_sel && bus_wr && (bus_addr == REG_STAT);
    assign wr_noise  = bus_sel && bus_wr && (bus_addr == REG_NOISE);
    assign wr_health = bus_sel && bus_wr && (bus_addr == REG_HEALTH);
    assign rd_data   = bus_sel && !bus_wr && (bus_addr == REG_DATA);

    assign busy        = cr_hold_q || (cr_cnt_q != '0);
    assign recond_done = (cr_cnt_q == CR_W'(1));
    assign seed_cur    = flags.seed_cur;
    assign run         = en_q && !busy && !seed_cur;
    assign pop         = rd_data && ready && !seed_cur;

    // Enable, lock and configuration commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lock_q <= 1'b0;
            cfg_q  <= '0;
        end else if (wr_ctrl) begin
            en_q <= bus_wdata[C_EN];
            if (bus_wdata[C_LOCK])
                lock_q <= 1'b1;
            if (bus_wdata[C_RECOND] && !lock_q)
                cfg_q <= bus_wdata & CFG_MASK;
        end
    end

    // Conditional reset: hold while requested, then count down after release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_hold_q <= 1'b0;
            cr_cnt_q  <= '0;
        end else if (wr_ctrl && bus_wdata[C_RECOND]) begin
            cr_hold_q <= 1'b1;
        end else if (wr_ctrl && cr_hold_q) begin
            cr_hold_q <= 1'b0;
            cr_cnt_q  <= CR_LOAD;
        end else if (cr_cnt_q != '0) begin
            cr_cnt_q <= cr_cnt_q - 1'b1;
        end
    end

    // Noise and health setup registers, frozen by the lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            noise_q  <= '0;
            health_q <= '0;
        end else begin
            if (wr_noise && !lock_q)
                noise_q <= bus_wdata[NOISE_W-1:0];
            if (wr_health && !lock_q)
                health_q <= bus_wdata;
        end
    end

    trng_word_source #(
        .DIV_W     (DIV_W),
        .WORD_TICKS(WORD_TICKS),
        .TAPS      (LFSR_TAPS),
        .SEED      (LFSR_SEED)
    ) u_src (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .pop  (pop),
        .div  (cfg_q[C_DIV_LO +: DIV_W]),
        .word (word),
        .ready(ready)
    );

    trng_status #(.AUTO_CYCLES(AUTO_CYCLES)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .inj_soft    (inj_seed_soft),
        .inj_fatal   (inj_seed_fatal),
        .clk_fault   (clk_fault),
        .clk_chk_en  (cfg_q[C_CLKCHK]),
        .recond_done (recond_done),
        .clr_seed_int(wr_stat && !bus_wdata[S_SEED_INT]),
        .clr_clk_int (wr_stat && !bus_wdata[S_CLK_INT]),
        .flags       (flags)
    );

    // Read-back multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata           = cfg_q;
                bus_rdata[C_EN]     = en_q;
                bus_rdata[C_RECOND] = busy;
                bus_rdata[C_LOCK]   = lock_q;
            end
            REG_STAT: begin
                bus_rdata[S_READY]    = ready;
                bus_rdata[S_CLK_CUR]  = flags.clk_cur;
                bus_rdata[S_SEED_CUR] = flags.seed_cur;
                bus_rdata[S_CLK_INT]  = flags.clk_int;
                bus_rdata[S_SEED_INT] = flags.seed_int;
            end
            REG_DATA:   bus_rdata = (ready && !seed_cur) ? word : 32'h0;
            REG_NOISE:  bus_rdata = 32'(noise_q);
            REG_HEALTH: bus_rdata = health_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/trng_ctrl_checker.sv
// Temporal checks on the random generator control unit, bound to its top.
// Observes the bus, the ready flag, the fault state and the control state.
module trng_ctrl_checker #(
    parameter int NOISE_W = 18
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_sel,
    input logic                        bus_wr,
    input logic [trng_pkg::ADDR_W-1:0] bus_addr,
    input logic [31:0]                 bus_wdata,
    input logic [31:0]                 bus_rdata,
    input logic                        ready,
    input logic                        seed_cur,
    input logic                        busy,
    input logic                        en_q,
    input logic                        lock_q,
    input logic [31:0]                 cfg_q,
    input logic [NOISE_W-1:0]          noise_q,
    input logic                        clk_int
);
    import trng_pkg::*;

    logic rd_data, wr_ctrl, wr_noise;
    assign rd_data  = bus_sel && !bus_wr && (bus_addr == REG_DATA);
    assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == REG_CTRL);
    assign wr_noise = bus_sel && bus_wr && (bus_addr == REG_NOISE);

    // R2: a ready word is never zero
    p_word_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && ready && !seed_cur) |-> (bus_rdata != 32'h0));

    // R3: a pop clears data-ready
    p_pop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && ready && !seed_cur) |=> !ready);

    // R3: an empty read returns zero
    p_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !ready) |-> (bus_rdata == 32'h0));

    // R5: configuration holds across writes without the reset bit
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata[C_RECOND]) |=> $stable(cfg_q));

    // R6: no word becomes ready during conditional reset
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ready);

    // R7: a current seed fault drops data-ready
    p_seed_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seed_cur |=> !ready);

    // R10: clock interrupt cannot rise while detection is off
    p_clk_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[C_CLKCHK] && !clk_int) |=> !clk_int);

    // R12: the lock is sticky
    p_lock_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R12: noise register frozen while locked
    p_noise_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && wr_noise) |=> $stable(noise_q));

    // R13: disabled unit holds no ready word
    p_disable_drops_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !ready);
endmodule

bind trng_ctrl_unit trng_ctrl_checker #(.NOISE_W(NOISE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ready    (ready),
    .seed_cur (seed_cur),
    .busy     (busy),
    .en_q     (en_q),
    .lock_q   (lock_q),
    .cfg_q    (cfg_q),
    .noise_q  (noise_q),
    .clk_int  (flags.clk_int)
);

// File: tb/tb_trng_ctrl_unit.sv
// Scoreboard bench: data-read tasks push the predicted word into a queue,
// and a monitor compares each captured read against the queue head.
module tb_trng_ctrl_unit;
    localparam int RSTC  = 4;
    localparam int AUTOC = 6;
    localparam logic [31:0] EN   = 32'h0000_0004;
    localparam logic [31:0] RC   = 32'h4000_0000;
    localparam logic [31:0] LK   = 32'h8000_0000;
    localparam logic [31:0] CFGV = 32'h00A3_5A04;
    localparam logic [31:0] CFGC = 32'h00A3_5A24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        inj_seed_soft = 1'b0, inj_seed_fatal = 1'b0, clk_fault = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_state = 32'h0000_0001;
    logic [31:0] exp_q[$];
    string       req_q[$];
    logic [31:0] mon_val;
    event        mon_ev;
    logic [31:0] rv;

    always #5 clk = ~clk;

    trng_ctrl_unit #(.RST_CYCLES(RSTC), .AUTO_CYCLES(AUTOC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .inj_seed_soft(inj_seed_soft), .inj_seed_fatal(inj_seed_fatal),
        .clk_fault(clk_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_step(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    task automatic next_word(output logic [31:0] w);
        for (int i = 0; i < 4; i++) m_state = m_step(m_state);
        w = m_state;
    endtask

    task automatic skip_word();
        logic [31:0] w;
        next_word(w);
    endtask

    // Bus tasks start at a falling edge and return at the next one
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_word(input string req);
        logic [31:0] w;
        next_word(w);
        exp_q.push_back(w); req_q.push_back(req);
        bus_read(5'h08, mon_val);
        ->mon_ev;
        #0;
    endtask

    task automatic read_empty(input string req);
        exp_q.push_back(32'h0); req_q.push_back(req);
        bus_read(5'h08, mon_val);
        ->mon_ev;
        #0;
    endtask

    task automatic wait_ready(input string req);
        logic [31:0] s;
        int n;
        n = 0;
        s = '0;
        while (!s[0] && n < 3000) begin
            bus_read(5'h04, s);
            n++;
        end
        if (!s[0]) chk(req, s, 32'h1);
    endtask

    task automatic cr_pulse(input logic [31:0] v);
        bus_write(5'h00, v | RC);
        bus_write(5'h00, v & ~RC);
        idle(RSTC + 1);
    endtask

    task automatic reconfig(input logic [31:0] v);
        wait_ready("R6");
        skip_word();
        cr_pulse(v);
    endtask

    // Pop a word, then count edges until data-ready returns
    task automatic measure(input string req, input int expn);
        logic [31:0] s;
        int n;
        read_word(req);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h04;
        n = 0;
        forever begin
            #2 s = bus_rdata;
            if (s[0] || n > 5000) break;
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        bus_sel = 1'b0;
        chk(req, 32'(n), 32'(expn));
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: compare each captured data read with the predicted item
    initial begin
        forever begin
            @(mon_ev);
            if (exp_q.size() == 0) begin
                chk("R2", mon_val, 32'hXXXX_XXXX);
            end else begin
                chk(req_q.pop_front(), mon_val, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset values
        bus_read(5'h00, rv); chk("R1", rv, 32'h0);
        bus_read(5'h04, rv); chk("R1", rv, 32'h0);
        bus_read(5'h08, rv); chk("R1", rv, 32'h0);
        bus_read(5'h0C, rv); chk("R1", rv, 32'h0);
        bus_read(5'h10, rv); chk("R1", rv, 32'h0);

        // R2: word sequence at divider 0
        bus_write(5'h00, EN);
        for (int i = 0; i < 3; i++) begin
            wait_ready("R2");
            read_word("R2");
        end

        // R3: pop clears ready, empty read gives zero
        wait_ready("R3");
        read_word("R3");
        bus_read(5'h04, rv); chk("R3", rv & 32'h1, 32'h0);
        read_empty("R3");

        // R4: divider 0 spacing
        wait_ready("R4");
        measure("R4", 4);

        // R5: configuration without the reset bit is ignored
        bus_write(5'h00, CFGV);
        bus_read(5'h00, rv); chk("R5", rv, EN);

        // R6: conditional reset commits and counts down
        wait_ready("R6");
        skip_word();
        bus_write(5'h00, CFGV | RC);
        bus_read(5'h00, rv); chk("R6", rv, CFGV | RC);
        bus_write(5'h00, CFGV);
        bus_read(5'h00, rv); chk("R6", rv, CFGV | RC);
        bus_read(5'h04, rv); chk("R6", rv & 32'h1, 32'h0);
        idle(RSTC - 1);
        bus_read(5'h00, rv); chk("R6", rv, CFGV);

        // R4: divider 3 spacing, R2 sequence continues
        wait_ready("R2");
        read_word("R2");
        wait_ready("R4");
        measure("R4", 32);

        // R13: disable drops ready and keeps configuration
        wait_ready("R13");
        bus_write(5'h00, CFGV & ~EN);
        idle(1);
        bus_read(5'h04, rv); chk("R13", rv & 32'h1, 32'h0);
        bus_read(5'h00, rv); chk("R13", rv, CFGV & ~EN);
        idle(200);
        bus_read(5'h04, rv); chk("R13", rv & 32'h1, 32'h0);
        bus_write(5'h00, CFGV);
        skip_word();
        wait_ready("R13");
        read_word("R13");

        // R7: recoverable seed fault
        wait_ready("R7");
        inj_seed_soft = 1'b1; @(negedge clk); inj_seed_soft = 1'b0;
        idle(1);
        bus_read(5'h04, rv); chk("R7", rv, 32'h44);
        read_empty("R7");
        idle(AUTOC);
        bus_read(5'h04, rv); chk("R7", rv & 32'h46, 32'h40);

        // R9: write 1 keeps the flag, write 0 clears it
        bus_write(5'h04, 32'hFFFF_FFFF);
        bus_read(5'h04, rv); chk("R9", rv & 32'h40, 32'h40);
        bus_write(5'h04, 32'h0);
        bus_read(5'h04, rv); chk("R9", rv & 32'h66, 32'h0);
        skip_word();
        wait_ready("R7");
        read_word("R7");

        // R8: persistent seed fault needs a conditional reset
        wait_ready("R8");
        inj_seed_fatal = 1'b1; @(negedge clk); inj_seed_fatal = 1'b0;
        idle(AUTOC + 4);
        bus_read(5'h04, rv); chk("R8", rv & 32'h46, 32'h44);
        cr_pulse(CFGV);
        bus_read(5'h04, rv); chk("R8", rv & 32'h66, 32'h0);
        skip_word();
        wait_ready("R8");
        read_word("R8");

        // R10: clock faults gated by detection enable
        clk_fault = 1'b1; idle(2);
        bus_read(5'h04, rv); chk("R10", rv & 32'h22, 32'h0);
        clk_fault = 1'b0;
        reconfig(CFGC);
        clk_fault = 1'b1; idle(2);
        bus_read(5'h04, rv); chk("R10", rv & 32'h22, 32'h22);
        clk_fault = 1'b0; idle(2);
        bus_read(5'h04, rv); chk("R10", rv & 32'h22, 32'h20);
        wait_ready("R10");
        read_word("R10");
        bus_write(5'h04, 32'h0);
        bus_read(5'h04, rv); chk("R9", rv & 32'h20, 32'h0);

        // R11: register widths
        bus_write(5'h0C, 32'hFFFF_FFFF);
        bus_read(5'h0C, rv); chk("R11", rv, 32'h0003_FFFF);
        bus_write(5'h10, 32'hC0FF_EE11);
        bus_read(5'h10, rv); chk("R11", rv, 32'hC0FF_EE11);

        // R12: lock freezes configuration and setup registers
        bus_write(5'h00, CFGC | LK);
        bus_read(5'h00, rv); chk("R12", rv, CFGC | LK);
        bus_write(5'h0C, 32'h0);
        bus_read(5'h0C, rv); chk("R12", rv, 32'h0003_FFFF);
        bus_write(5'h10, 32'h0);
        bus_read(5'h10, rv); chk("R12", rv, 32'hC0FF_EE11);
        reconfig(EN);
        bus_read(5'h00, rv); chk("R12", rv, CFGC | LK);
        wait_ready("R12");
        read_word("R12");

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule